// File: doc/BRIEF.md
# SDRAM Bank State Tracker with Concurrent Auto Precharge

This block sits on the controller side of an SDRAM interface. It watches the command stream that the controller has already registered, and it keeps a state for each bank of a four-bank device. It also predicts when the device will drive read data. A scheduler uses the outputs to decide which bank may be activated next, when read data will arrive, and when DQM has to mask the bus before a write.

Each bank is idle, open, running an access with auto precharge, or precharging. The tracker supports concurrent auto precharge. When an accepted READ or WRITE goes to another bank while a read with auto precharge is running, that read burst is cut short and its bank starts precharging on the same edge. A read cut by a later READ keeps its data on the bus until the new data arrives one CAS latency later. A WRITE stops read data at once.

Burst length, CAS latency and the single-write burst mode come from a mode-register-set command. In single-write burst mode every write is one beat long, while reads still use the programmed burst length.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset all banks read idle, every ready flag is 1, and rd_valid_o, dqm_req_o and proto_err_o are 0. Bank b reports its state on bank_state_o[2b+1:2b] with the codes idle=0, open=1, auto-precharge burst=2, precharging=3.
- R2: Commands on cmd_i use the codes NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, MODE-SET=5, and any other code acts as NOP. An ACTIVATE to an idle bank opens it from the next cycle, and an ACTIVATE to a bank that is not idle has no effect. A PRECHARGE to an open bank makes it precharge for T_RP cycles and then go idle. PRECHARGE to any other bank is ignored. bank_ready_o[b] is 1 only while bank b is idle.
- R3: A READ with ap_i=1 to an open bank keeps that bank in the auto-precharge burst state for burst-length cycles, then precharging for T_RP cycles, then idle. A READ with ap_i=0 leaves the bank open.
- R4: A WRITE with ap_i=1 to an open bank keeps that bank in the auto-precharge burst state for the write length plus T_DPL cycles, then precharging for T_RP cycles, then idle. The write length is the burst length, or 1 when single-write mode is set.
- R5: Reads follow the programmed burst length whether single-write mode is set or not.
- R6: For an accepted READ registered at edge n, rd_valid_o is 1 after edges n+CL through n+CL+BL-1.
- R7: An accepted READ cuts any earlier read data. The earlier data continues until the new data starts, CL cycles after the new READ.
- R8: An accepted READ or WRITE to bank m moves every other bank that is in an auto-precharge read burst into precharging after that same edge. That bank then goes idle T_RP cycles later.
- R9: An accepted WRITE removes all pending and current read data, so rd_valid_o and dqm_req_o are 0 after that edge.
- R10: dqm_req_o is 1 exactly when, with no further commands, rd_valid_o would be 1 in at least one of the next three cycles.
- R11: A READ or WRITE to a bank that is not open sets proto_err_o for the next cycle. It changes no bank state and affects neither rd_valid_o nor the interruption of other banks.
- R12: A MODE-SET command loads the CAS latency from mrs_cl3_i (0 gives 2, 1 gives 3), the burst length from mrs_bl_i (codes 0 to 3 give 1, 2, 4, 8) and single-write mode from mrs_wbm_i. The reset values are CL 3, burst length 4 and single-write mode off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Registered command code |
| bank_i | input | 2 | Target bank of the command |
| ap_i | input | 1 | Auto precharge flag of READ/WRITE |
| mrs_wbm_i | input | 1 | Single-write burst mode, loaded on MODE-SET |
| mrs_bl_i | input | 2 | Burst length code, loaded on MODE-SET |
| mrs_cl3_i | input | 1 | CAS latency select, loaded on MODE-SET |
| bank_state_o | output | 8 | Packed 2-bit state per bank |
| bank_ready_o | output | 4 | Bank may be activated |
| rd_valid_o | output | 1 | Read data expected on the bus this cycle |
| dqm_req_o | output | 1 | Read data due within three cycles; mask before a write |
| proto_err_o | output | 1 | Previous READ/WRITE hit a bank that was not open |

## Verification
Two things can happen on the same edge. A cut-off bank can move into precharging while the new access is accepted on another bank, and its own countdown can end at that same moment. Also, a new read token can load while an older burst is still counting down. Back-to-back reads and writes on different banks with auto precharge set create both overlaps. The random phase adds many more interleavings. Every cycle, each bank state, the read strobe and the mask flag are compared against a bench model that schedules data beats per cycle from the requirement rules.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_MRS = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_APBURST = 2'd2,
        BK_PRECH   = 2'd3
    } bank_st_e;
endpackage

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank
    import sdram_trk_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic             ap_i,
    input  logic             cut_i,
    input  logic [CNT_W-1:0] rd_len_i,
    input  logic [CNT_W-1:0] wr_len_i,
    output bank_st_e         state_o,
    output logic             ready_o
);
    localparam logic [CNT_W-1:0] RP_CNT = CNT_W'(T_RP);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic             is_rd;
    } bk_t;

    bk_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        case (bk_q.st)
            BK_APBURST: begin
                if (bk_q.cnt == CNT_W'(1)) begin
                    bk_d.st  = BK_PRECH;
                    bk_d.cnt = RP_CNT;
                end else begin
                    bk_d.cnt = bk_q.cnt - CNT_W'(1);
                end
            end
            BK_PRECH: begin
                if (bk_q.cnt == CNT_W'(1)) begin
                    bk_d.st  = BK_IDLE;
                    bk_d.cnt = '0;
                end else begin
                    bk_d.cnt = bk_q.cnt - CNT_W'(1);
                end
            end
            default: ;
        endcase
        if (act_i && bk_q.st == BK_IDLE) begin
            bk_d.st = BK_OPEN;
        end
        if (pre_i && bk_q.st == BK_OPEN) begin
            bk_d.st  = BK_PRECH;
            bk_d.cnt = RP_CNT;
        end
        if (rd_i && ap_i) begin
            bk_d.st    = BK_APBURST;
            bk_d.cnt   = rd_len_i;
            bk_d.is_rd = 1'b1;
        end
        if (wr_i && ap_i) begin
            bk_d.st    = BK_APBURST;
            bk_d.cnt   = wr_len_i;
            bk_d.is_rd = 1'b0;
        end
        if (cut_i && bk_q.st == BK_APBURST && bk_q.is_rd) begin
            bk_d.st  = BK_PRECH;
            bk_d.cnt = RP_CNT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '{st: BK_IDLE, cnt: '0, is_rd: 1'b0};
        end else begin
            bk_q <= bk_d;
        end
    end

    assign state_o = bk_q.st;
    assign ready_o = (bk_q.st == BK_IDLE);

    // R8: a cut read burst starts precharging on the cutting edge
    assert_cut_prech_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_i && state_o == BK_APBURST && bk_q.is_rd) |=> state_o == BK_PRECH);
    // R2: precharging never jumps straight to open
    assert_prech_not_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == BK_PRECH) |=> state_o != BK_OPEN);
    // R3: accepted read with auto precharge enters the burst state
    assert_rdap_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ap_i) |=> state_o == BK_APBURST);
endmodule

// File: rtl/sdram_trk_rdpipe.sv
module sdram_trk_rdpipe #(
    parameter int BL_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic            cl3_i,
    input  logic [BL_W-1:0] bl_i,
    output logic            valid_o,
    output logic            dqm_o
);
    localparam int PIPE_D = 3;

    typedef struct packed {
        logic [PIPE_D-1:0] pipe;
        logic [BL_W-1:0]   left;
    } rp_t;

    rp_t rp_d, rp_q;
    logic load;

    always_comb begin
        rp_d = rp_q;
        load = cl3_i ? rp_q.pipe[2] : rp_q.pipe[1];
        rp_d.pipe = {rp_q.pipe[PIPE_D-2:0], rd_i};
        if (load) begin
            rp_d.left = bl_i;
        end else if (rp_q.left != '0) begin
            rp_d.left = rp_q.left - BL_W'(1);
        end
        if (wr_i) begin
            rp_d.pipe = '0;
            rp_d.left = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign valid_o = (rp_q.left != '0);
    assign dqm_o   = (rp_q.left > BL_W'(1)) | rp_q.pipe[0] | rp_q.pipe[1]
                   | (cl3_i & rp_q.pipe[2]);

    // R9: a write empties the read data path
    assert_wr_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (!valid_o && !dqm_o));
    // R10: data on the bus next cycle implies the mask request now
    assert_dqm_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !rd_i && dqm_o == 1'b0) |=> !valid_o);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 3,
    parameter int T_DPL     = 2,
    parameter int MAX_BL    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             cmd_i,
    input  logic [1:0]             bank_i,
    input  logic                   ap_i,
    input  logic                   mrs_wbm_i,
    input  logic [1:0]             mrs_bl_i,
    input  logic                   mrs_cl3_i,
    output logic [2*NUM_BANKS-1:0] bank_state_o,
    output logic [NUM_BANKS-1:0]   bank_ready_o,
    output logic                   rd_valid_o,
    output logic                   dqm_req_o,
    output logic                   proto_err_o
);
    localparam int BANK_W = 2;
    localparam int CNT_W  = $clog2(MAX_BL + T_DPL + T_RP + 1);
    localparam int BL_W   = $clog2(MAX_BL + 1);

    typedef struct packed {
        logic       cl3;
        logic [1:0] bl_code;
        logic       wbm;
        logic       err;
    } top_t;

    top_t top_d, top_q;
    cmd_e cmd;
    logic is_act, is_pre, is_rd, is_wr, is_mrs, acc;
    logic [BL_W-1:0]  bl_cnt;
    logic [CNT_W-1:0] rd_len, wr_len;
    bank_st_e bk_st [NUM_BANKS];

    always_comb begin
        cmd    = cmd_e'(cmd_i);
        is_act = (cmd == CMD_ACT);
        is_pre = (cmd == CMD_PRE);
        is_rd  = (cmd == CMD_RD);
        is_wr  = (cmd == CMD_WR);
        is_mrs = (cmd == CMD_MRS);
        acc    = (is_rd || is_wr) && (bk_st[bank_i] == BK_OPEN);
        bl_cnt = BL_W'(1) << top_q.bl_code;
        rd_len = CNT_W'(bl_cnt);
        wr_len = (top_q.wbm ? CNT_W'(1) : CNT_W'(bl_cnt)) + CNT_W'(T_DPL);

        top_d     = top_q;
        top_d.err = (is_rd || is_wr) && !acc;
        if (is_mrs) begin
            top_d.cl3     = mrs_cl3_i;
            top_d.bl_code = mrs_bl_i;
            top_d.wbm     = mrs_wbm_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '{cl3: 1'b1, bl_code: 2'd2, wbm: 1'b0, err: 1'b0};
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel;
        assign sel = (bank_i == BANK_W'(g));
        sdram_trk_bank #(.T_RP(T_RP), .CNT_W(CNT_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (is_act && sel),
            .pre_i    (is_pre && sel),
            .rd_i     (is_rd && acc && sel),
            .wr_i     (is_wr && acc && sel),
            .ap_i     (ap_i),
            .cut_i    (acc && !sel),
            .rd_len_i (rd_len),
            .wr_len_i (wr_len),
            .state_o  (bk_st[g]),
            .ready_o  (bank_ready_o[g])
        );
        assign bank_state_o[2*g +: 2] = bk_st[g];
    end

    sdram_trk_rdpipe #(.BL_W(BL_W)) u_rdpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (is_rd && acc),
        .wr_i    (is_wr && acc),
        .cl3_i   (top_q.cl3),
        .bl_i    (bl_cnt),
        .valid_o (rd_valid_o),
        .dqm_o   (dqm_req_o)
    );

    assign proto_err_o = top_q.err;

    // R11: an access to a closed bank flags an error next cycle
    assert_closed_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_rd || is_wr) && bk_st[bank_i] == BK_IDLE) |=> proto_err_o);
    // R11: the closed idle bank stays idle
    assert_closed_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_rd || is_wr) && bk_st[bank_i] == BK_IDLE) |=> bk_st[$past(bank_i)] == BK_IDLE);
endmodule

// File: tb/sdram_bank_tracker_test.sv
`timescale 1ns/1ps
module sdram_bank_tracker_test;
    localparam int T_RP  = 3;
    localparam int T_DPL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [1:0] bank = 2'd0;
    logic       ap = 1'b0;
    logic       mwbm = 1'b0;
    logic [1:0] mbl = 2'd2;
    logic       mcl3 = 1'b1;
    logic [7:0] bank_state;
    logic [3:0] bank_ready;
    logic       rd_valid, dqm_req, proto_err;

    always #2.5 clk = ~clk;

    sdram_bank_tracker uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
        .mrs_wbm_i(mwbm), .mrs_bl_i(mbl), .mrs_cl3_i(mcl3),
        .bank_state_o(bank_state), .bank_ready_o(bank_ready),
        .rd_valid_o(rd_valid), .dqm_req_o(dqm_req), .proto_err_o(proto_err)
    );

    int tests = 0;
    int fails = 0;
    int n = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_st[4], m_cnt[4];
    bit m_isrd[4];
    int m_cl = 3, m_bl = 4;
    bit m_wbm = 0, m_err = 0;
    bit valid_at[0:8191];

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d exp %0d at cycle %0d", tag, got, exp, n);
        end
    endtask

    task automatic model(input int c, input int b, input bit a);
        int nst[4], ncnt[4];
        bit nrd[4];
        bit accd;
        n++;
        accd  = (c == 2 || c == 3) && m_st[b] == 1;
        m_err = (c == 2 || c == 3) && !accd;
        for (int k = 0; k < 4; k++) begin
            nst[k] = m_st[k]; ncnt[k] = m_cnt[k]; nrd[k] = m_isrd[k];
            if (m_st[k] == 2) begin
                if (m_cnt[k] == 1) begin nst[k] = 3; ncnt[k] = T_RP; end
                else ncnt[k] = m_cnt[k] - 1;
            end else if (m_st[k] == 3) begin
                if (m_cnt[k] == 1) begin nst[k] = 0; ncnt[k] = 0; end
                else ncnt[k] = m_cnt[k] - 1;
            end
            if (k == b) begin
                if (c == 1 && m_st[k] == 0) nst[k] = 1;
                if (c == 4 && m_st[k] == 1) begin nst[k] = 3; ncnt[k] = T_RP; end
                if (accd && a && c == 2) begin nst[k] = 2; ncnt[k] = m_bl; nrd[k] = 1; end
                if (accd && a && c == 3) begin
                    nst[k] = 2; ncnt[k] = (m_wbm ? 1 : m_bl) + T_DPL; nrd[k] = 0;
                end
            end else if (accd && m_st[k] == 2 && m_isrd[k]) begin
                nst[k] = 3; ncnt[k] = T_RP;
            end
        end
        for (int k = 0; k < 4; k++) begin
            m_st[k] = nst[k]; m_cnt[k] = ncnt[k]; m_isrd[k] = nrd[k];
        end
        if (accd && c == 2) begin
            for (int i = n + m_cl; i < n + 20; i++) valid_at[i] = 0;
            for (int i = 0; i < m_bl; i++) valid_at[n + m_cl + i] = 1;
        end
        if (accd && c == 3) begin
            for (int i = n; i < n + 20; i++) valid_at[i] = 0;
        end
        if (c == 5) begin
            m_cl = mcl3 ? 3 : 2; m_bl = 1 << mbl; m_wbm = mwbm;
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < 4; k++) begin
            chk({cur_req, " bank state"}, int'(bank_state[2*k +: 2]), m_st[k]);
            chk("R2 ready", int'(bank_ready[k]), int'(m_st[k] == 0));
        end
        chk("R6 rd_valid", int'(rd_valid), int'(valid_at[n]));
        chk("R10 dqm_req", int'(dqm_req),
            int'(valid_at[n+1] | valid_at[n+2] | valid_at[n+3]));
        chk("R11 proto_err", int'(proto_err), int'(m_err));
    endtask

    task automatic step(input int c, input int b, input bit a);
        @(negedge clk);
        cmd = 3'(c); bank = 2'(b); ap = a;
        @(posedge clk);
        #1;
        model(c, b, a);
        compare_all();
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0);
    endtask

    task automatic mrs(input bit cl3, input int blc, input bit wbm);
        @(negedge clk);
        mcl3 = cl3; mbl = 2'(blc); mwbm = wbm;
        step(5, 0, 0);
    endtask

    task automatic rand_phase(input int steps);
        for (int i = 0; i < steps; i++) begin
            int r = $urandom % 16;
            int b = $urandom % 4;
            bit a = 1'($urandom % 2);
            if (r < 4) step(1, b, 0);
            else if (r < 8) step(2, b, a);
            else if (r < 11) step(3, b, a);
            else if (r < 12) step(4, b, 0);
            else step(0, 0, 0);
        end
        idle(20);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8192; i++) valid_at[i] = 0;
        for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_cnt[k] = 0; m_isrd[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        cur_req = "R1";
        chk("R1 reset states", int'(bank_state), 0);
        chk("R1 reset ready", int'(bank_ready), 15);
        chk("R1 reset strobes", int'({rd_valid, dqm_req, proto_err}), 0);

        cur_req = "R2";
        step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); step(4, 0, 0); idle(5);
        step(1, 1, 0); step(4, 2, 0); step(4, 1, 0); idle(5);

        cur_req = "R3";
        step(1, 0, 0); step(2, 0, 1); idle(10);
        step(1, 0, 0); step(2, 0, 0); idle(8); step(4, 0, 0); idle(4);

        cur_req = "R12";
        mrs(1'b0, 3, 1'b1);
        cur_req = "R4";
        step(1, 1, 0); step(3, 1, 1); idle(8);
        cur_req = "R5";
        step(1, 2, 0); step(2, 2, 0); idle(12);
        step(3, 2, 0); step(4, 2, 0); idle(4);

        cur_req = "R12";
        mrs(1'b1, 2, 1'b0);
        cur_req = "R7";
        step(1, 0, 0); step(1, 1, 0); step(2, 0, 1); step(0, 0, 0); step(2, 1, 0);
        cur_req = "R8";
        idle(3); step(2, 1, 1); step(2, 2, 0); idle(10);

        cur_req = "R9";
        step(1, 1, 0); step(2, 1, 0); step(0, 0, 0); step(3, 1, 0); idle(3);
        step(2, 1, 0); step(3, 1, 1); idle(10);

        cur_req = "R11";
        step(2, 3, 1); step(3, 3, 0); step(1, 0, 0); step(2, 0, 1); step(2, 3, 0); idle(10);

        cur_req = "R8";
        rand_phase(1500);
        cur_req = "R12";
        mrs(1'b0, 1, 1'b1);
        cur_req = "R7";
        rand_phase(1500);
        cur_req = "R12";
        mrs(1'b1, 0, 1'b0);
        cur_req = "R4";
        rand_phase(800);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired at cycle %0d", n);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule